// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit is the write guard of a serial byte-addressed memory. It owns the write enable latch and a small status byte holding two nonvolatile block protection bits, the latch bit and the busy bit. A command engine presents decoded, fully framed commands to it: set enable, clear enable, status write, and array write commit. A page buffer reports when an array programming cycle is running. The unit answers, from current state, whether an array address may be written and whether the status byte may be written.

The protection bits lock a region at the top of the array: nothing, the upper quarter, the upper half or the whole array. The active-low hardware write-protect input overrides both the latch and the protection bits. While it is low the latch is held clear and every write is refused. A status write that is accepted starts its own timed busy cycle, and every command presented while busy is dropped. The nonvolatile bits are modelled as a register whose reset value locks the upper quarter, where identification bytes live.

Top module: `wr_guard`

## Requirements
- R1: After reset the status byte reads 8'h04: protection code 01 in bits 3:2, latch bit 1 clear, busy bit 0 clear.
- R2: A set-enable command (op 0) sets the latch bit 1 and a clear-enable command (op 1) clears it, one cycle after the command, when the unit is idle and the protect input is high.
- R3: While the protect input is low the latch is cleared on the next clock, and a set-enable command has no effect.
- R4: The array permit is 1 only when the protect input is high, the latch is set, the unit is idle and the queried address is outside the locked region. Code 00 locks nothing, 01 the top quarter (top two address bits 11), 10 the top half (top address bit 1), 11 everything.
- R5: The status permit is 1 exactly when the protect input is high, the latch is set and the unit is idle.
- R6: An accepted status write (op 2) copies data bits 3:2 into the protection code, clears the latch and drives the busy bit high for exactly SR_CYC samples after the command, then low.
- R7: A status write that is not permitted changes neither the protection code nor the latch.
- R8: An array commit (op 3) to a permitted address clears the latch; a commit to a locked address leaves the latch unchanged.
- R9: The busy bit also follows the page buffer busy input, and while busy both permits are 0 and every command is ignored.
- R10: Status bits 7:4 always read 0, whatever data a status write carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | One-cycle strobe of a completed command |
| cmd_op | input | 2 | 0 set enable, 1 clear enable, 2 status write, 3 array commit |
| cmd_addr | input | AW | Page address of an array commit |
| cmd_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Hardware write protect, low blocks all writes |
| pb_busy | input | 1 | Page buffer programming cycle in progress |
| qry_addr | input | AW | Array address to test for write permission |
| arr_permit | output | 1 | Queried address may be written |
| sr_permit | output | 1 | Status byte may be written |
| status_byte | output | 8 | Status byte as read by the host |

## Verification
The bench builds the unit with an 8-bit address and a four-cycle status write busy time. The narrow address makes it practical to sweep every address under each of the four protection codes and every combination of latch and protect input, with permits computed arithmetically. The short busy time allows the busy window to be checked sample by sample at both of its edges.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

    typedef enum logic [1:0] {
        OP_SET_EN     = 2'd0,
        OP_CLR_EN     = 2'd1,
        OP_STAT_WR    = 2'd2,
        OP_ARR_COMMIT = 2'd3
    } guard_op_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic [1:0] lock;
        logic       wel;
        logic       wip;
    } stat_t;

    localparam logic [1:0] LOCK_RESET = 2'b01;

    // top2: the two most significant address bits
    function automatic logic region_locked(input logic [1:0] lock,
                                           input logic [1:0] top2);
        logic r;
        case (lock)
            2'b00:   r = 1'b0;
            2'b01:   r = (top2 == 2'b11);
            2'b10:   r = top2[1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wr_guard_latch.sv
module wr_guard_latch (
    input  logic clk,
    input  logic rst,
    input  logic wp_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic wel
);
    always_ff @(posedge clk) begin
        if (rst || !wp_n)
            wel <= 1'b0;
        else if (clr_ev)
            wel <= 1'b0;
        else if (set_ev)
            wel <= 1'b1;
    end

    assert_wel_reset_R1: assert property (@(posedge clk) rst |=> !wel);
    assert_wel_clear_wp_R3: assert property (@(posedge clk) disable iff (rst)
        !wp_n |=> !wel);
endmodule

// File: rtl/wr_guard_lockreg.sv
module wr_guard_lockreg #(
    parameter int SR_CYC = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  logic [1:0] new_lock,
    output logic [1:0] lock,
    output logic       sr_busy
);
    import wr_guard_pkg::*;

    localparam int TW = $clog2(SR_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(SR_CYC);

    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock  <= LOCK_RESET;
            timer <= '0;
        end else if (commit) begin
            lock  <= new_lock;
            timer <= LOAD;
        end else if (timer != '0) begin
            timer <= timer - 1'b1;
        end
    end

    assign sr_busy = (timer != '0);

    assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> sr_busy);
    assert_lock_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(lock));
endmodule

// File: rtl/wr_guard_region.sv
module wr_guard_region #(
    parameter int AW = 8
) (
    input  logic [1:0]    lock,
    input  logic [AW-1:0] addr,
    output logic          locked
);
    import wr_guard_pkg::*;

    assign locked = region_locked(lock, addr[AW-1 -: 2]);
endmodule

// File: rtl/wr_guard.sv
module wr_guard #(
    parameter int AW     = 8,
    parameter int SR_CYC = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_vld,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic          wp_n,
    input  logic          pb_busy,
    input  logic [AW-1:0] qry_addr,
    output logic          arr_permit,
    output logic          sr_permit,
    output logic [7:0]    status_byte
);
    import wr_guard_pkg::*;

    localparam int NCHK = 2;

    guard_op_e     op;
    logic          wel, sr_busy, wip, accept;
    logic [1:0]    lock;
    logic          set_ev, clr_ev, sr_commit, arr_ok;
    logic [AW-1:0] chk_addr [NCHK];
    logic [NCHK-1:0] chk_locked;
    stat_t         st;

    assign op          = guard_op_e'(cmd_op);
    assign chk_addr[0] = qry_addr;
    assign chk_addr[1] = cmd_addr;

    for (genvar g = 0; g < NCHK; g++) begin : g_region
        wr_guard_region #(.AW(AW)) u_region (
            .lock   (lock),
            .addr   (chk_addr[g]),
            .locked (chk_locked[g])
        );
    end

    assign wip        = sr_busy | pb_busy;
    assign sr_permit  = wp_n & wel & ~wip;
    assign arr_permit = sr_permit & ~chk_locked[0];
    assign arr_ok     = sr_permit & ~chk_locked[1];

    assign accept    = cmd_vld & ~wip;
    assign set_ev    = accept & (op == OP_SET_EN);
    assign sr_commit = accept & (op == OP_STAT_WR) & sr_permit;
    assign clr_ev    = accept & ((op == OP_CLR_EN) | sr_commit |
                                 ((op == OP_ARR_COMMIT) & arr_ok));

    wr_guard_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .wp_n   (wp_n),
        .set_ev (set_ev),
        .clr_ev (clr_ev),
        .wel    (wel)
    );

    wr_guard_lockreg #(.SR_CYC(SR_CYC)) u_lockreg (
        .clk      (clk),
        .rst      (rst),
        .commit   (sr_commit),
        .new_lock (cmd_data[3:2]),
        .lock     (lock),
        .sr_busy  (sr_busy)
    );

    always_comb begin
        st.rsvd = 4'b0000;
        st.lock = lock;
        st.wel  = wel;
        st.wip  = wip;
    end
    assign status_byte = st;

    assert_no_permit_busy_R9: assert property (@(posedge clk) disable iff (rst)
        status_byte[0] |-> (!arr_permit && !sr_permit));
    assert_full_lock_denies_R4: assert property (@(posedge clk) disable iff (rst)
        (status_byte[3:2] == 2'b11) |-> !arr_permit);
    assert_busy_ignores_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && status_byte[0] && wp_n) |=> $stable(status_byte[1]));
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        status_byte[7:4] == 4'b0000);
endmodule

// File: tb/wr_guard_bench.sv
`timescale 1ns/1ps
module wr_guard_bench;
    localparam int AW     = 8;
    localparam int SR_CYC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_vld = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          wp_n = 1'b1;
    logic          pb_busy = 1'b0;
    logic [AW-1:0] qry_addr = '0;
    logic          arr_permit, sr_permit;
    logic [7:0]    status_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wr_guard #(.AW(AW), .SR_CYC(SR_CYC)) u_wr_guard (
        .clk, .rst, .cmd_vld, .cmd_op, .cmd_addr, .cmd_data,
        .wp_n, .pb_busy, .qry_addr, .arr_permit, .sr_permit, .status_byte
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    function automatic logic locked_m(input int b, input int a);
        return (b == 3) || (b == 2 && a >= 128) || (b == 1 && a >= 192);
    endfunction

    task automatic set_lock(input int b);
        wp_n = 1'b1;
        do_cmd(2'd0, 8'h00, 8'h00);
        do_cmd(2'd2, 8'h00, {4'hA, 2'(b), 2'b11});
        repeat (SR_CYC) @(negedge clk);
        chk(status_byte, {4'h0, 2'(b), 2'b00}, "R6 lock code after status write");
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(status_byte, 8'h04, "R1 reset status");
        chk(sr_permit, 1'b0, "R5 no permit after reset");

        // R2 set and clear
        do_cmd(2'd0, 8'h00, 8'h00);
        chk(status_byte, 8'h06, "R2 set enable");
        chk(sr_permit, 1'b1, "R5 status permit with latch");
        do_cmd(2'd1, 8'h00, 8'h00);
        chk(status_byte, 8'h04, "R2 clear enable");

        // R6 / R10 accepted status write, busy window
        do_cmd(2'd0, 8'h00, 8'h00);
        do_cmd(2'd2, 8'h00, 8'hF3);
        for (int k = 0; k < SR_CYC; k++) begin
            chk(status_byte, 8'h01, "R6 busy window, R10 upper zero");
            @(negedge clk);
        end
        chk(status_byte, 8'h00, "R6 busy ends, latch cleared");

        // R7 denied status write (latch clear)
        do_cmd(2'd2, 8'h00, 8'h0C);
        chk(status_byte, 8'h00, "R7 denied without latch");
        // R7 denied with protect input low
        do_cmd(2'd0, 8'h00, 8'h00);
        wp_n = 1'b0;
        do_cmd(2'd2, 8'h00, 8'h0C);
        chk(status_byte, 8'h00, "R7 denied with protect low");

        // R3 set enable ignored while protect low
        do_cmd(2'd0, 8'h00, 8'h00);
        chk(status_byte[1], 1'b0, "R3 set ignored while protect low");
        wp_n = 1'b1;
        do_cmd(2'd0, 8'h00, 8'h00);
        @(negedge clk); wp_n = 1'b0;
        @(negedge clk);
        chk(status_byte[1], 1'b0, "R3 protect low clears latch");
        wp_n = 1'b1;

        // R8 array commit
        set_lock(1);
        do_cmd(2'd0, 8'h00, 8'h00);
        do_cmd(2'd3, 8'hC5, 8'h00);
        chk(status_byte[1], 1'b1, "R8 locked commit keeps latch");
        do_cmd(2'd3, 8'h10, 8'h00);
        chk(status_byte[1], 1'b0, "R8 permitted commit clears latch");

        // R9 page buffer busy
        @(negedge clk); pb_busy = 1'b1;
        do_cmd(2'd0, 8'h00, 8'h00);
        chk(status_byte, 8'h05, "R9 busy ignores set enable");
        @(negedge clk); pb_busy = 1'b0;
        do_cmd(2'd0, 8'h00, 8'h00);
        @(negedge clk); pb_busy = 1'b1;
        #1;
        chk(arr_permit, 1'b0, "R9 no array permit while busy");
        chk(sr_permit, 1'b0, "R9 no status permit while busy");
        do_cmd(2'd1, 8'h00, 8'h00);
        chk(status_byte[1], 1'b1, "R9 busy ignores clear enable");
        @(negedge clk); pb_busy = 1'b0;

        // R4 / R5 sweep
        for (int b = 0; b < 4; b++) begin
            set_lock(b);
            for (int w = 0; w < 2; w++) begin
                for (int e = 0; e < 2; e++) begin
                    wp_n = 1'b1;
                    do_cmd(e ? 2'd0 : 2'd1, 8'h00, 8'h00);
                    @(negedge clk);
                    wp_n = w[0];
                    for (int a = 0; a < 256; a++) begin
                        qry_addr = 8'(a);
                        #1;
                        chk(arr_permit, w[0] & e[0] & ~locked_m(b, a), "R4 array permit sweep");
                    end
                    chk(sr_permit, w[0] & e[0], "R5 status permit");
                end
            end
        end
        wp_n = 1'b1;

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(status_byte, 8'h04, "R1 status after second reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule